// File: doc/BRIEF.md
# Host-to-Coprocessor Command Mailbox

This block sits between a host CPU and a secure coprocessor. The host reaches it over a simple 32-bit register bus. The host stages sixteen argument words and then writes a command word. That command write takes a snapshot of the staged arguments together with the command and places it in a small first-in first-out command queue. On the other side, the coprocessor takes entries from the head of the queue through a valid/ready handshake. When it finishes a command, it posts a return value and sixteen status words through a single-cycle done strobe.

Three events are recorded as pending interrupt causes: command completion, a write to an argument register while the queue is full, and a command dropped because the queue is full. Each cause is cleared by writing a one to its bit. A mask register sets which causes drive the single interrupt output. The mask starts out with every cause disabled. A queue status register reports the current occupancy and a ready flag that follows a ready input from the coprocessor.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, the queue is empty: occupancy reads 0 and `cp_req_valid` is 0. No cause is pending (offset 0xC8 reads 0), the mask at offset 0xCC reads 0xFFFFFFFF, `irq` is 0 and the ready flag reads 0.
- R2: The sixteen argument words at offsets 0x00 to 0x3C (word i at 4*i) and the command word at 0x40 read back the last value written to them.
- R3: A write to offset 0x40 while occupancy is below 4 queues the written command together with the sixteen argument words staged at that moment. The coprocessor port delivers queued entries in the order they were written, each on `cp_req_cmd` and `cp_req_args` (argument i in bits 32*i+31:32*i), with `cp_req_valid` high while the queue is not empty.
- R4: The queue status register at 0xC4 holds the occupancy in bits 2:0 and the ready flag in bit 8. The ready flag is `cp_ready_in` registered once.
- R5: A write to 0x40 while occupancy is 4 is dropped: occupancy and queue contents stay unchanged, and cause bit 18 becomes pending.
- R6: A write to any argument offset while occupancy is 4 sets cause bit 17. The write itself still updates the argument word.
- R7: A cycle with `cp_done` high loads `cp_retval` into the return register at 0x80 and `cp_status` word i into the status register at 0x84+4*i, and sets cause bit 0.
- R8: Writing to 0xC8 clears each pending cause whose bit in the written data is 1 and leaves the other causes unchanged.
- R9: `irq` is high exactly when some pending cause (bit 0, 17 or 18) has a 0 in the corresponding bit of the mask register at 0xCC.
- R10: Reads of offsets that are not mapped (for example 0x44 and 0xD0) return 0.
- R11: Each handshake on the coprocessor port (`cp_req_valid` and `cp_req_ready` both high) removes one entry. A pop and an accepted command write in the same cycle leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register bus access strobe |
| bus_we | input | 1 | Write enable (1 = write, 0 = read) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request, from pending causes that are not masked |
| cp_ready_in | input | 1 | Coprocessor ready indication |
| cp_req_valid | output | 1 | Head-of-queue entry available |
| cp_req_ready | input | 1 | Coprocessor accepts the head entry |
| cp_req_cmd | output | 32 | Command word of the head entry |
| cp_req_args | output | 512 | Sixteen argument words of the head entry |
| cp_done | input | 1 | Result strobe from the coprocessor |
| cp_retval | input | 32 | Return value posted with `cp_done` |
| cp_status | input | 512 | Sixteen status words posted with `cp_done` |

## Verification
The bench fills the queue to its limit and then tries a fifth command. A design that miscounts at the boundary would accept the command and overwrite the oldest entry, or fail to raise bit 18. The bench also writes an argument while the queue is full, to catch a design that confuses the two full-related causes. A command write that lands in the same cycle as a pop must leave the occupancy at one. A design that lets the pop or the push win would show 0 or 2. Masking and write-one-to-clear are exercised one cause at a time. A design that clears every cause at once, or that ignores the mask polarity, would show wrong status bits or a stray `irq`.

// File: rtl/cmd_mailbox.sv
module cmd_mailbox #(
  parameter int DEPTH = 4,
  parameter int NARG  = 16,
  parameter int DW    = 32,
  parameter int AW    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               irq,
  input  logic               cp_ready_in,
  output logic               cp_req_valid,
  input  logic               cp_req_ready,
  output logic [DW-1:0]      cp_req_cmd,
  output logic [NARG*DW-1:0] cp_req_args,
  input  logic               cp_done,
  input  logic [DW-1:0]      cp_retval,
  input  logic [NARG*DW-1:0] cp_status
);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int AIW = $clog2(NARG);
  localparam logic [AW-1:0] OFS_CMD  = AW'(4 * NARG);
  localparam logic [AW-1:0] OFS_RET  = AW'(8'h80);
  localparam logic [AW-1:0] OFS_STS  = AW'(8'h84);
  localparam logic [AW-1:0] OFS_STSL = AW'(8'h84 + 4 * (NARG - 1));
  localparam logic [AW-1:0] OFS_QST  = AW'(8'hC4);
  localparam logic [AW-1:0] OFS_ISR  = AW'(8'hC8);
  localparam logic [AW-1:0] OFS_IMR  = AW'(8'hCC);

  logic [DW-1:0] arg_r [NARG];
  logic [DW-1:0] sts_r [NARG];
  logic [DW-1:0] cmd_r, ret_r, mask_r;
  logic [DW-1:0] q_cmd [DEPTH];
  logic [DW-1:0] q_arg [DEPTH][NARG];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          rdy_q;
  logic [2:0]    pend;

  wire wr       = bus_sel & bus_we;
  wire arg_hit  = bus_addr < OFS_CMD;
  wire sts_hit  = (bus_addr >= OFS_STS) && (bus_addr <= OFS_STSL) && (bus_addr[1:0] == 2'b00);
  wire [AIW-1:0] arg_idx = bus_addr[2 +: AIW];
  wire [AW-1:0]  sts_off = bus_addr - OFS_STS;
  wire [AIW-1:0] sts_idx = sts_off[2 +: AIW];
  wire full     = cnt == CW'(DEPTH);
  wire cmd_wr   = wr && bus_addr == OFS_CMD;
  wire push     = cmd_wr && !full;
  wire drop     = cmd_wr && full;
  wire acc_full = wr && arg_hit && full;
  wire pop      = cp_req_valid && cp_req_ready;
  wire isr_wr   = wr && bus_addr == OFS_ISR;
  wire [2:0] clr = isr_wr ? {bus_wdata[18], bus_wdata[17], bus_wdata[0]} : 3'b000;
  wire [2:0] set = {drop, acc_full, cp_done};

  assign cp_req_valid = cnt != '0;
  assign cp_req_cmd   = q_cmd[rp];
  assign irq          = |(pend & ~{mask_r[18], mask_r[17], mask_r[0]});

  for (genvar i = 0; i < NARG; i++) begin : g_out
    assign cp_req_args[i*DW +: DW] = q_arg[rp][i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NARG; i++) begin
        arg_r[i] <= '0;
        sts_r[i] <= '0;
      end
      cmd_r  <= '0;
      ret_r  <= '0;
      mask_r <= '1;
      rdy_q  <= 1'b0;
      pend   <= '0;
    end else begin
      rdy_q <= cp_ready_in;
      pend  <= (pend & ~clr) | set;
      if (wr && arg_hit) arg_r[arg_idx] <= bus_wdata;
      if (cmd_wr) cmd_r <= bus_wdata;
      if (wr && bus_addr == OFS_IMR) mask_r <= bus_wdata;
      if (cp_done) begin
        ret_r <= cp_retval;
        for (int i = 0; i < NARG; i++) sts_r[i] <= cp_status[i*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        q_cmd[wp] <= bus_wdata;
        for (int i = 0; i < NARG; i++) q_arg[wp][i] <= arg_r[i];
        wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      end
      if (pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      if (push && !pop) cnt <= cnt + CW'(1);
      else if (pop && !push) cnt <= cnt - CW'(1);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (arg_hit) bus_rdata = arg_r[arg_idx];
    else if (sts_hit) bus_rdata = sts_r[sts_idx];
    else begin
      case (bus_addr)
        OFS_CMD: bus_rdata = cmd_r;
        OFS_RET: bus_rdata = ret_r;
        OFS_QST: begin
          bus_rdata[CW-1:0] = cnt;
          bus_rdata[8]      = rdy_q;
        end
        OFS_ISR: begin
          bus_rdata[0]  = pend[0];
          bus_rdata[17] = pend[1];
          bus_rdata[18] = pend[2];
        end
        OFS_IMR: bus_rdata = mask_r;
        default: bus_rdata = '0;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH)); // R5
  AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    drop && !pop |=> cnt == $past(cnt) && pend[2]); // R5
  AST_PUSH_INC: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |=> cnt == $past(cnt) + CW'(1)); // R3
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push |=> cnt == $past(cnt) - CW'(1)); // R11
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n) cp_done |=> pend[0]); // R7
  AST_ACC_FLAG: assert property (@(posedge clk) disable iff (!rst_n) acc_full |=> pend[1]); // R6
endmodule

// File: tb/cmd_mailbox_tb.sv
module cmd_mailbox_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         irq;
  logic         cp_ready_in = 1'b0;
  logic         cp_req_valid;
  logic         cp_req_ready = 1'b0;
  logic [31:0]  cp_req_cmd;
  logic [511:0] cp_req_args;
  logic         cp_done = 1'b0;
  logic [31:0]  cp_retval = '0;
  logic [511:0] cp_status = '0;

  int checks = 0, errors = 0;
  logic [63:0] exp_q[$];
  logic [31:0] rd;

  always #5 clk = ~clk;

  cmd_mailbox u_dut (.*);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cp_req_valid && cp_req_ready) begin
      if (exp_q.size() == 0) chk("R3 unexpected pop", cp_req_cmd, 32'hxxxx_xxxx);
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk("R3 cmd", cp_req_cmd, e[63:32]);
        chk("R3 arg0", cp_req_args[31:0], e[31:0]);
        chk("R3 arg15", cp_req_args[511:480], e[31:0] + 32'd15);
      end
    end
  end

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(posedge clk) #1;
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk) #1;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(posedge clk) #1;
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic send_cmd(logic [31:0] cmd, logic [31:0] base, bit accept);
    for (int i = 0; i < 16; i++) bus_write(8'(4 * i), base + 32'(i));
    if (accept) exp_q.push_back({cmd, base});
    bus_write(8'h40, cmd);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    bus_read(8'hC4, rd); chk("R1 qstat", rd, 32'h0);
    bus_read(8'hC8, rd); chk("R1 isr", rd, 32'h0);
    bus_read(8'hCC, rd); chk("R1 mask", rd, 32'hFFFF_FFFF);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 valid", {31'b0, cp_req_valid}, 32'h0);

    cp_ready_in = 1;
    bus_read(8'hC4, rd); chk("R4 ready flag", rd, 32'h100);

    send_cmd(32'hC000_0001, 32'h1000, 1);
    send_cmd(32'hC000_0002, 32'h2000, 1);
    send_cmd(32'hC000_0003, 32'h3000, 1);
    send_cmd(32'hC000_0004, 32'h4000, 1);
    bus_read(8'hC4, rd); chk("R4 occupancy full", rd, 32'h104);
    bus_read(8'h14, rd); chk("R2 arg5", rd, 32'h4005);
    bus_read(8'h40, rd); chk("R2 cmd", rd, 32'hC000_0004);

    send_cmd(32'hDEAD_0005, 32'h5000, 0);
    bus_read(8'hC4, rd); chk("R5 occupancy held", rd, 32'h104);
    bus_read(8'hC8, rd); chk("R5 R6 causes", rd, 32'h0006_0000);
    bus_read(8'h3C, rd); chk("R6 arg written", rd, 32'h500F);
    chk("R9 irq masked", {31'b0, irq}, 32'h0);

    bus_write(8'hCC, 32'hFFFD_FFFF);
    bus_read(8'hC8, rd);
    chk("R9 irq on", {31'b0, irq}, 32'h1);
    bus_write(8'hC8, 32'h0002_0000);
    bus_read(8'hC8, rd); chk("R8 partial clear", rd, 32'h0004_0000);
    chk("R9 irq off", {31'b0, irq}, 32'h0);
    bus_write(8'hC8, 32'h0004_0000);
    bus_read(8'hC8, rd); chk("R8 clear all", rd, 32'h0);

    @(posedge clk) #1 cp_req_ready = 1;
    repeat (6) @(posedge clk);
    #1 cp_req_ready = 0;
    bus_read(8'hC4, rd); chk("R11 drained", rd, 32'h100);
    chk("R3 all delivered", exp_q.size(), 0);

    send_cmd(32'hA000_0001, 32'h6000, 1);
    exp_q.push_back({32'hA000_0002, 32'h6000});
    @(posedge clk) #1;
    cp_req_ready = 1; bus_sel = 1; bus_we = 1; bus_addr = 8'h40; bus_wdata = 32'hA000_0002;
    @(posedge clk) #1;
    cp_req_ready = 0; bus_sel = 0; bus_we = 0;
    bus_read(8'hC4, rd); chk("R11 push and pop", rd, 32'h101);
    @(posedge clk) #1 cp_req_ready = 1;
    repeat (3) @(posedge clk);
    #1 cp_req_ready = 0;
    bus_read(8'hC4, rd); chk("R11 empty again", rd, 32'h100);

    @(posedge clk) #1;
    cp_done = 1; cp_retval = 32'h0000_BEEF;
    for (int i = 0; i < 16; i++) cp_status[i*32 +: 32] = 32'hA000_0000 + 32'(i);
    @(posedge clk) #1 cp_done = 0;
    bus_read(8'h80, rd); chk("R7 retval", rd, 32'h0000_BEEF);
    bus_read(8'h84, rd); chk("R7 status0", rd, 32'hA000_0000);
    bus_read(8'hC0, rd); chk("R7 status15", rd, 32'hA000_000F);
    bus_read(8'hC8, rd); chk("R7 done cause", rd, 32'h1);
    chk("R9 still masked", {31'b0, irq}, 32'h0);
    bus_write(8'hCC, 32'hFFFF_FFFE);
    bus_read(8'hC8, rd);
    chk("R9 done irq", {31'b0, irq}, 32'h1);

    bus_read(8'h44, rd); chk("R10 hole 0x44", rd, 32'h0);
    bus_read(8'hD0, rd); chk("R10 hole 0xD0", rd, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule